// File: doc/BRIEF.md
# Root Hub Port Status and Control Registers

This block holds the status and control register for each downstream port of a USB 1.1 root hub. There is one register cell per port. Software reaches all of them through one 16-bit write path and one read path, and each access selects a port by index. The hub side reports device events on per-port strobes: a device was plugged in (together with a low-speed flag), a device was removed, or a device asked for remote wakeup. The register folds these events into its connect, enable and resume bits.

A software write keeps a fixed set of status bits unchanged. It loads the remaining bits from the written word, and it clears the two change flags wherever the written word holds a 1. When software moves the port-reset bit from 0 to 1, the port sends a single-cycle request to drive a bus reset. A wakeup that arrives while the port is suspended sets the resume-detect bit and sends a single-cycle resume pulse to the controller. A read of an index that has no port behind it returns a fixed pattern. Reads have one cycle of latency.

Top module: `hub_port_regs`

## Requirements
- R1: After a synchronous reset, every port register reads 0x0000, `rd_data` is 0x0000, and `bus_reset`, `resume_det` and `port_ready` are all low.
- R2: The register bits are: connected at bit 0, connect change at bit 1, enabled at bit 2, enable change at bit 3, resume detected at bit 6, low-speed device at bit 8, port reset at bit 9, suspend at bit 12. `rd_data` shows the register selected by `rd_idx` one clock after `rd_idx` is presented.
- R3: A write keeps every bit in mask 0x01BB unchanged and loads every other bit from `wr_data`.
- R4: After the R3 merge, a write clears bit 1 and bit 3 wherever `wr_data` has a 1 in that position.
- R5: A write with bit 9 set, to a port whose bit 9 is currently 0, raises that port's `bus_reset` bit for exactly one cycle, in the cycle after the write. Any other write leaves `bus_reset` low.
- R6: Attach sets bits 0 and 1, and sets bit 8 equal to `low_speed` for that port.
- R7: Detach of a connected port clears bit 0 and sets bit 1. Detach of an enabled port clears bit 2 and sets bit 3. Detach of a port that is neither connected nor enabled changes nothing.
- R8: A wakeup request while bit 12 is 1 and bit 6 is 0 sets bit 6 and pulses `resume_det` for one cycle, in the cycle after the request. In any other state the request has no effect.
- R9: A read of an index at or above NUM_PORTS returns 0xFF7F.
- R10: `port_ready` for a port is high exactly when bits 0 and 2 of that port are both 1.
- R11: A write or event for one port leaves every other port's register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Port index of the write |
| wr_data | input | 16 | Write data |
| rd_idx | input | IDX_W | Port index of the read |
| rd_data | output | 16 | Registered read data |
| attach | input | NUM_PORTS | Per-port device attach strobe |
| low_speed | input | NUM_PORTS | Per-port low-speed flag, sampled on attach |
| detach | input | NUM_PORTS | Per-port device detach strobe |
| wake_req | input | NUM_PORTS | Per-port remote wakeup request |
| bus_reset | output | NUM_PORTS | Per-port one-cycle bus reset request |
| resume_det | output | 1 | One-cycle resume pulse to the controller |
| port_ready | output | NUM_PORTS | Port is connected and enabled |

## Verification
The hardest case to reach is the resume path. A wakeup has an effect only after software has set suspend through a write, and only while resume-detect is still clear. The bench therefore first sends a wakeup to a port that is not suspended and confirms that nothing happens. It then writes the suspend bit, sends the wakeup again to get the pulse and the status bit, and sends a third wakeup to confirm that a port already showing resume-detect produces no second pulse. The bus reset edge is reached in the same way: one write takes bit 9 from 0 to 1, and a repeated write with bit 9 already set must stay silent.

// File: rtl/hub_port_pkg.sv
package hub_port_pkg;

  localparam int REG_W = 16;

  localparam int B_CONN    = 0;
  localparam int B_CONN_CH = 1;
  localparam int B_EN      = 2;
  localparam int B_EN_CH   = 3;
  localparam int B_RESUME  = 6;
  localparam int B_LOWSPD  = 8;
  localparam int B_PRST    = 9;
  localparam int B_SUSP    = 12;

  localparam logic [REG_W-1:0] KEEP_MASK  = 16'h01BB;
  localparam logic [REG_W-1:0] CLR1_MASK  = 16'h000A;
  localparam logic [REG_W-1:0] ABSENT_VAL = 16'hFF7F;

  // Merge a software write into the current register value.
  function automatic logic [REG_W-1:0] merge_write(
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] wd
  );
    logic [REG_W-1:0] v;
    v = (cur & KEEP_MASK) | (wd & ~KEEP_MASK);
    v = v & ~(wd & CLR1_MASK);
    return v;
  endfunction

endpackage

// File: rtl/hub_port_cell.sv
module hub_port_cell
  import hub_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wr_data,
  input  logic             attach,
  input  logic             low_speed,
  input  logic             detach,
  input  logic             wake,
  output logic [REG_W-1:0] q,
  output logic             bus_rst_pulse,
  output logic             resume_pulse
);

  logic [REG_W-1:0] nxt;
  logic             fire_rst;
  logic             fire_resume;

  always_comb begin
    nxt = q;
    if (wr_hit) begin
      nxt = merge_write(q, wr_data);
    end
    // Hardware events are applied after the software write.
    if (detach) begin
      if (nxt[B_CONN]) begin
        nxt[B_CONN]    = 1'b0;
        nxt[B_CONN_CH] = 1'b1;
      end
      if (nxt[B_EN]) begin
        nxt[B_EN]    = 1'b0;
        nxt[B_EN_CH] = 1'b1;
      end
    end
    if (attach) begin
      nxt[B_CONN]    = 1'b1;
      nxt[B_CONN_CH] = 1'b1;
      nxt[B_LOWSPD]  = low_speed;
    end
    if (fire_resume) begin
      nxt[B_RESUME] = 1'b1;
    end
  end

  assign fire_rst    = wr_hit && wr_data[B_PRST] && !q[B_PRST];
  assign fire_resume = wake && q[B_SUSP] && !q[B_RESUME];

  always_ff @(posedge clk) begin
    if (rst) begin
      q             <= '0;
      bus_rst_pulse <= 1'b0;
      resume_pulse  <= 1'b0;
    end else begin
      q             <= nxt;
      bus_rst_pulse <= fire_rst;
      resume_pulse  <= fire_resume;
    end
  end

endmodule

// File: rtl/hub_port_rdmux.sv
module hub_port_rdmux
  import hub_port_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int IDX_W     = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_PORTS-1:0][REG_W-1:0] regs,
  input  logic [IDX_W-1:0]                rd_idx,
  output logic [REG_W-1:0]                rd_data
);

  logic [REG_W-1:0] sel;

  always_comb begin
    sel = ABSENT_VAL;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (int'(rd_idx) == i) begin
        sel = regs[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= sel;
    end
  end

endmodule

// File: rtl/hub_port_regs.sv
module hub_port_regs
  import hub_port_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [15:0]          wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [15:0]          rd_data,
  input  logic [NUM_PORTS-1:0] attach,
  input  logic [NUM_PORTS-1:0] low_speed,
  input  logic [NUM_PORTS-1:0] detach,
  input  logic [NUM_PORTS-1:0] wake_req,
  output logic [NUM_PORTS-1:0] bus_reset,
  output logic                 resume_det,
  output logic [NUM_PORTS-1:0] port_ready
);

  logic [NUM_PORTS-1:0][REG_W-1:0] port_q;
  logic [NUM_PORTS-1:0]            wr_hit;
  logic [NUM_PORTS-1:0]            resume_vec;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    assign wr_hit[g] = wr_en && (int'(wr_idx) == g);

    hub_port_cell u_cell (
      .clk           (clk),
      .rst           (rst),
      .wr_hit        (wr_hit[g]),
      .wr_data       (wr_data),
      .attach        (attach[g]),
      .low_speed     (low_speed[g]),
      .detach        (detach[g]),
      .wake          (wake_req[g]),
      .q             (port_q[g]),
      .bus_rst_pulse (bus_reset[g]),
      .resume_pulse  (resume_vec[g])
    );

    assign port_ready[g] = port_q[g][B_CONN] && port_q[g][B_EN];
  end

  assign resume_det = |resume_vec;

  hub_port_rdmux #(
    .NUM_PORTS (NUM_PORTS),
    .IDX_W     (IDX_W)
  ) u_rdmux (
    .clk     (clk),
    .rst     (rst),
    .regs    (port_q),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/hub_port_regs_chk.sv
module hub_port_regs_chk #(
  parameter int NUM_PORTS = 2,
  parameter int IDX_W     = 3
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        wr_en,
  input logic [IDX_W-1:0]            wr_idx,
  input logic [IDX_W-1:0]            rd_idx,
  input logic [15:0]                 rd_data,
  input logic [NUM_PORTS-1:0]        attach,
  input logic [NUM_PORTS-1:0]        detach,
  input logic [NUM_PORTS-1:0]        wake_req,
  input logic [NUM_PORTS-1:0]        bus_reset,
  input logic                        resume_det,
  input logic [NUM_PORTS-1:0][15:0]  port_q
);

  // R9: an absent index reads the fixed pattern one cycle later
  a_r9_absent_read: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(int'(rd_idx) >= NUM_PORTS)) |-> rd_data == 16'hFF7F);

  // R8: a resume pulse only follows a wakeup request
  a_r8_resume_cause: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && resume_det) |-> $past(|wake_req));

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_chk
    // R5: the bus reset request lasts a single cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
      bus_reset[g] |=> !bus_reset[g]);

    // R5: a bus reset request needs a write to this port
    a_r5_needs_write: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && bus_reset[g]) |-> $past(wr_en && int'(wr_idx) == g));

    // R7: detach of a port leaves it disconnected with the change flag up
    a_r7_detach: assert property (@(posedge clk) disable iff (rst)
      (detach[g] && !attach[g] && port_q[g][0]) |=> (!port_q[g][0] && port_q[g][1]));

    // R3: kept bits do not move on a write without hardware events
    a_r3_keep_bits: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(wr_en && int'(wr_idx) == g && !attach[g] && !detach[g]))
        |-> ((port_q[g] & 16'h01B1) == ($past(port_q[g]) & 16'h01B1)));
  end

endmodule

bind hub_port_regs hub_port_regs_chk #(
  .NUM_PORTS (NUM_PORTS),
  .IDX_W     (IDX_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .rd_idx     (rd_idx),
  .rd_data    (rd_data),
  .attach     (attach),
  .detach     (detach),
  .wake_req   (wake_req),
  .bus_reset  (bus_reset),
  .resume_det (resume_det),
  .port_q     (port_q)
);

// File: tb/hub_port_regs_tb.sv
module hub_port_regs_tb;

  localparam int NP = 2;
  localparam int IW = 3;

  localparam logic [3:0] OP_WR  = 4'd0;
  localparam logic [3:0] OP_RD  = 4'd1;
  localparam logic [3:0] OP_ATT = 4'd2;
  localparam logic [3:0] OP_DET = 4'd3;

  // {op, idx, arg, expected}
  localparam int NV = 30;
  localparam logic [39:0] VEC [NV] = '{
    {OP_RD,  4'd0, 16'h0000, 16'h0000},  // R1 reset value
    {OP_ATT, 4'd0, 16'h0001, 16'h0000},
    {OP_RD,  4'd0, 16'h0000, 16'h0103},  // R6 low-speed attach
    {OP_WR,  4'd0, 16'h0004, 16'h0000},
    {OP_RD,  4'd0, 16'h0000, 16'h0107},  // R3 enable written
    {OP_WR,  4'd0, 16'h0006, 16'h0000},
    {OP_RD,  4'd0, 16'h0000, 16'h0105},  // R4 connect change cleared
    {OP_WR,  4'd0, 16'h01F0, 16'h0000},
    {OP_RD,  4'd0, 16'h0000, 16'h0141},  // R3 kept bits, enable dropped
    {OP_WR,  4'd0, 16'h0004, 16'h0000},
    {OP_RD,  4'd0, 16'h0000, 16'h0105},  // R3
    {OP_DET, 4'd0, 16'h0000, 16'h0000},
    {OP_RD,  4'd0, 16'h0000, 16'h010A},  // R7 both change flags up
    {OP_WR,  4'd0, 16'h000A, 16'h0000},
    {OP_RD,  4'd0, 16'h0000, 16'h0100},  // R4 both flags cleared
    {OP_ATT, 4'd0, 16'h0000, 16'h0000},
    {OP_RD,  4'd0, 16'h0000, 16'h0003},  // R6 full-speed attach
    {OP_RD,  4'd1, 16'h0000, 16'h0000},  // R11 other port untouched
    {OP_RD,  4'd2, 16'h0000, 16'hFF7F},  // R9 first absent index
    {OP_RD,  4'd7, 16'h0000, 16'hFF7F},  // R9 last index
    {OP_ATT, 4'd1, 16'h0000, 16'h0000},
    {OP_WR,  4'd1, 16'hE404, 16'h0000},
    {OP_RD,  4'd1, 16'h0000, 16'hE407},  // R3 upper writable bits
    {OP_RD,  4'd0, 16'h0000, 16'h0003},  // R11
    {OP_WR,  4'd1, 16'h0000, 16'h0000},
    {OP_RD,  4'd1, 16'h0000, 16'h0003},  // R3
    {OP_DET, 4'd1, 16'h0000, 16'h0000},
    {OP_RD,  4'd1, 16'h0000, 16'h0002},  // R7 connected, not enabled
    {OP_DET, 4'd1, 16'h0000, 16'h0000},
    {OP_RD,  4'd1, 16'h0000, 16'h0002}   // R7 detach when idle
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [IW-1:0]  wr_idx = '0;
  logic [15:0]    wr_data = '0;
  logic [IW-1:0]  rd_idx = '0;
  logic [15:0]    rd_data;
  logic [NP-1:0]  attach = '0;
  logic [NP-1:0]  low_speed = '0;
  logic [NP-1:0]  detach = '0;
  logic [NP-1:0]  wake_req = '0;
  logic [NP-1:0]  bus_reset;
  logic           resume_det;
  logic [NP-1:0]  port_ready;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  hub_port_regs #(.NUM_PORTS(NP), .IDX_W(IW)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .attach     (attach),
    .low_speed  (low_speed),
    .detach     (detach),
    .wake_req   (wake_req),
    .bus_reset  (bus_reset),
    .resume_det (resume_det),
    .port_ready (port_ready)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input int p, input logic [15:0] d);
    wr_en = 1'b1; wr_idx = IW'(p); wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input int p, output logic [15:0] v);
    rd_idx = IW'(p);
    @(posedge clk); @(negedge clk);
    v = rd_data;
  endtask

  task automatic pulse_evt(input int kind, input int p, input logic ls);
    case (kind)
      0: begin attach[p] = 1'b1; low_speed[p] = ls; end
      1: detach[p] = 1'b1;
      default: wake_req[p] = 1'b1;
    endcase
    @(posedge clk); @(negedge clk);
    attach = '0; detach = '0; wake_req = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rd_data", rd_data, 16'h0000);
    check("R1 pulses", {14'd0, bus_reset}, 16'h0000);
    check("R1 ready", {15'd0, resume_det}, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      logic [3:0]  op;
      int          idx;
      logic [15:0] arg, ex;
      op = VEC[k][39:36]; idx = int'(VEC[k][35:32]);
      arg = VEC[k][31:16]; ex = VEC[k][15:0];
      case (op)
        OP_WR:  do_write(idx, arg);
        OP_ATT: pulse_evt(0, idx, arg[0]);
        OP_DET: pulse_evt(1, idx, 1'b0);
        default: begin
          do_read(idx, v);
          check($sformatf("R2 table entry %0d", k), v, ex);
        end
      endcase
    end

    // R5: 0 -> 1 on the reset bit requests a bus reset
    do_write(1, 16'h0200);
    check("R5 pulse high", {14'd0, bus_reset}, 16'h0002);
    @(negedge clk);
    check("R5 pulse ends", {14'd0, bus_reset}, 16'h0000);
    do_read(1, v);
    check("R5 reset bit", v, 16'h0202);
    do_write(1, 16'h0200);
    check("R5 no pulse when already set", {14'd0, bus_reset}, 16'h0000);

    // R8: wakeup without suspend has no effect
    pulse_evt(2, 1, 1'b0);
    check("R8 no resume unsuspended", {15'd0, resume_det}, 16'h0000);
    do_read(1, v);
    check("R8 register unchanged", v, 16'h0202);
    do_write(1, 16'h1000);
    pulse_evt(2, 1, 1'b0);
    check("R8 resume pulse", {15'd0, resume_det}, 16'h0001);
    @(negedge clk);
    check("R8 resume ends", {15'd0, resume_det}, 16'h0000);
    do_read(1, v);
    check("R8 resume bit", v, 16'h1042);
    pulse_evt(2, 1, 1'b0);
    check("R8 no repeat pulse", {15'd0, resume_det}, 16'h0000);

    // R10: ready needs connected and enabled
    check("R10 connected only", {14'd0, port_ready}, 16'h0000);
    do_write(0, 16'h0004);
    check("R10 ready", {14'd0, port_ready}, 16'h0001);
    pulse_evt(1, 0, 1'b0);
    check("R10 after detach", {14'd0, port_ready}, 16'h0000);

    // R1: reset in mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 rd_data after reset", rd_data, 16'h0000);
    do_read(0, v);
    check("R1 port0 cleared", v, 16'h0000);
    do_read(1, v);
    check("R1 port1 cleared", v, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule